// File: doc/BRIEF.md
# Core Power-Up and Clock-Ramp Sequencer

This block is a synchronous state machine that takes a processor core from a cold, unpowered condition to normal operation. It can also take the core back down into a low-power sleep or into a held reset. It watches the supply and power-good indications, the core's active-low reset and a clock-forwarding reset handshake. It also watches the done flags of the built-in self-test and self-initialization engines, a sleep request and a wake interrupt. From these it produces the two PLL divider settings (X and Z), the enables for the two self-check engines and a code for its current state.

The clock frequency rises and falls in fixed steps. Every ramp step and the fault-recovery hold are timed by an internal duration timer, which reloads each time a timed state is entered. A cold boot runs self-test and self-initialization. A wake from sleep and a recovery from a held reset both skip those engines and go straight to the clock-forwarding handshake.

Top module: `core_pwr_sequencer`

## Requirements
- R1: While `por_n` is low, `state_code` is 0 (OFF), `div_x`/`div_z` are 16/32 and both engine enables are 0, whatever the other inputs do.
- R2: OFF moves to SETTLE (code 1) when `supply_ok` is high and `core_rst_n` is low. SETTLE moves to LOCK (code 2) when `pwr_good` is high. Divisors are 16/32 in codes 0, 1 and 2.
- R3: LOCK moves to RAMP-UP-A (code 3, divisors 2/4) when `core_rst_n` is high. The machine stays in code 3 for exactly RAMP1_CYCLES cycles and then enters RAMP-UP-B (code 4).
- R4: RAMP-UP-B (divisors 1/2) lasts RAMP_CYCLES cycles. On a cold boot it then enters SELFTEST (code 5); otherwise it enters FWD-WAIT-A (code 7).
- R5: SELFTEST drives `selftest_en` high and moves on `selftest_done` to SELFINIT (code 6). SELFINIT drives `selfinit_en` high and moves on `selfinit_done` to code 7. The two enables are never high together.
- R6: FWD-WAIT-A moves to FWD-WAIT-B (code 8) when `fwd_rst` is high. FWD-WAIT-B moves to RUN (code 9) when `fwd_rst` is low. Divisors are 1/2 in codes 4 through 10.
- R7: RUN moves to RAMP-DOWN-A (code 10) on `sleep_req` high or `core_rst_n` low. Codes 10 (1/2), 11 (2/4) and 12 (16/32) each last RAMP_CYCLES cycles, in that order.
- R8: When code 12 ends, the machine enters SLEEP (code 13) if the RUN exit was caused by `sleep_req` with `core_rst_n` high. Otherwise it enters HOLD (code 14). Both use 16/32.
- R9: SLEEP moves to code 3 on `wake_irq`. That ramp-up then skips both self-check engines (code 4 is followed by code 7).
- R10: HOLD moves to FAULT-RECOVER (code 15, 16/32) when `core_rst_n` is high. Code 15 lasts FAULT_CYCLES cycles and is followed by code 3. That ramp-up also skips the self-check engines.
- R11: Inputs that the current state does not wait for have no effect. In LOCK, `selftest_done`, `wake_irq` and `fwd_rst` leave the state unchanged. In SELFTEST, `selfinit_done` leaves it unchanged.
- R12: `state_code`, the divisors and the enables are registered and change on the same clock edge. In every cycle they match the per-state table given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core reference clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Core and PLL supplies present |
| pwr_good | input | 1 | Power-good indication |
| core_rst_n | input | 1 | Core reset request, active low |
| fwd_rst | input | 1 | Clock-forwarding reset handshake |
| selftest_done | input | 1 | Self-test engine finished |
| selfinit_done | input | 1 | Self-initialization engine finished |
| sleep_req | input | 1 | Request to enter sleep |
| wake_irq | input | 1 | Enabled interrupt, wakes from sleep |
| state_code | output | 4 | Current state code |
| div_x | output | DIV_X_W | PLL X divisor |
| div_z | output | DIV_Z_W | PLL Z divisor |
| selftest_en | output | 1 | Self-test engine enable |
| selfinit_en | output | 1 | Self-initialization engine enable |

## Verification
The checker watches a set of properties in every cycle. It checks the divisor pair and the enables that belong to each state code, and it checks that the two enables are exclusive. It checks the allowed successors of the branching states and the exact dwell in RAMP-UP-A. The difference between the cold-boot, wake and fault-recovery paths depends on the history before the current state, so only the bench's scenarios show it. The same holds for the sleep-versus-hold choice made at RUN exit and for the ignored inputs in waiting states. The bench therefore runs a cold boot, a sleep/wake cycle and a reset-hold recovery, and it measures each timed dwell.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;

   typedef enum logic [3:0] {
      ST_OFF      = 4'd0,
      ST_SETTLE   = 4'd1,
      ST_LOCK     = 4'd2,
      ST_UP_A     = 4'd3,
      ST_UP_B     = 4'd4,
      ST_SELFTEST = 4'd5,
      ST_SELFINIT = 4'd6,
      ST_FWD_A    = 4'd7,
      ST_FWD_B    = 4'd8,
      ST_RUN      = 4'd9,
      ST_DN_A     = 4'd10,
      ST_DN_B     = 4'd11,
      ST_DN_C     = 4'd12,
      ST_SLEEP    = 4'd13,
      ST_HOLD     = 4'd14,
      ST_FAULT    = 4'd15
   } seq_state_e;

   localparam int unsigned DIV_SLOW = 16;
   localparam int unsigned DIV_MID  = 2;
   localparam int unsigned DIV_FAST = 1;

   // X divisor per state; Z is always twice X in this ramp scheme.
   function automatic int unsigned div_x_of(seq_state_e s);
      case (s)
         ST_UP_A, ST_DN_B: return DIV_MID;
         ST_UP_B, ST_SELFTEST, ST_SELFINIT, ST_FWD_A, ST_FWD_B, ST_RUN, ST_DN_A:
            return DIV_FAST;
         default: return DIV_SLOW;
      endcase
   endfunction

   function automatic int unsigned div_z_of(seq_state_e s);
      return 2 * div_x_of(s);
   endfunction

   typedef enum logic [1:0] {
      DUR_NONE  = 2'd0,
      DUR_RAMP1 = 2'd1,
      DUR_RAMP  = 2'd2,
      DUR_FAULT = 2'd3
   } dur_sel_e;

   function automatic dur_sel_e dur_of(seq_state_e s);
      case (s)
         ST_UP_A:                        return DUR_RAMP1;
         ST_UP_B, ST_DN_A, ST_DN_B, ST_DN_C: return DUR_RAMP;
         ST_FAULT:                       return DUR_FAULT;
         default:                        return DUR_NONE;
      endcase
   endfunction

endpackage

// File: rtl/core_seq_timer.sv
module core_seq_timer #(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             load,
   input  logic             timed,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (load) begin
         cnt_q   <= load_val;
         armed_q <= timed;
      end else if (armed_q) begin
         if (cnt_q == '0) armed_q <= 1'b0;
         else             cnt_q   <= cnt_q - 1'b1;
      end
   end

   assign done = armed_q && (cnt_q == '0);
endmodule

// File: rtl/core_seq_fsm.sv
module core_seq_fsm
   import core_seq_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       supply_ok,
   input  logic       pwr_good,
   input  logic       core_rst_n,
   input  logic       fwd_rst,
   input  logic       selftest_done,
   input  logic       selfinit_done,
   input  logic       sleep_req,
   input  logic       wake_irq,
   input  logic       timer_done,
   output seq_state_e state_q,
   output seq_state_e state_d
);
   logic cold_q;
   logic sleep_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_OFF:      if (supply_ok && !core_rst_n) state_d = ST_SETTLE;
         ST_SETTLE:   if (pwr_good)                 state_d = ST_LOCK;
         ST_LOCK:     if (core_rst_n)               state_d = ST_UP_A;
         ST_UP_A:     if (timer_done)               state_d = ST_UP_B;
         ST_UP_B:     if (timer_done)               state_d = cold_q ? ST_SELFTEST : ST_FWD_A;
         ST_SELFTEST: if (selftest_done)            state_d = ST_SELFINIT;
         ST_SELFINIT: if (selfinit_done)            state_d = ST_FWD_A;
         ST_FWD_A:    if (fwd_rst)                  state_d = ST_FWD_B;
         ST_FWD_B:    if (!fwd_rst)                 state_d = ST_RUN;
         ST_RUN:      if (sleep_req || !core_rst_n) state_d = ST_DN_A;
         ST_DN_A:     if (timer_done)               state_d = ST_DN_B;
         ST_DN_B:     if (timer_done)               state_d = ST_DN_C;
         ST_DN_C:     if (timer_done)               state_d = sleep_q ? ST_SLEEP : ST_HOLD;
         ST_SLEEP:    if (wake_irq)                 state_d = ST_UP_A;
         ST_HOLD:     if (core_rst_n)               state_d = ST_FAULT;
         ST_FAULT:    if (timer_done)               state_d = ST_UP_A;
         default:                                   state_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= ST_OFF;
         cold_q  <= 1'b1;
         sleep_q <= 1'b0;
      end else begin
         state_q <= state_d;
         // Path memory: only a ramp started from LOCK runs the self-check engines.
         if (state_q == ST_LOCK && state_d == ST_UP_A)
            cold_q <= 1'b1;
         else if ((state_q == ST_SLEEP || state_q == ST_FAULT) && state_d == ST_UP_A)
            cold_q <= 1'b0;
         // Reset request overrides a simultaneous sleep request.
         if (state_q == ST_RUN && state_d == ST_DN_A)
            sleep_q <= sleep_req && core_rst_n;
      end
   end
endmodule

// File: rtl/core_seq_outreg.sv
module core_seq_outreg
   import core_seq_pkg::*;
#(
   parameter int unsigned DIV_X_W = 5,
   parameter int unsigned DIV_Z_W = 6,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               por_n,
   input  seq_state_e         state_d,
   input  seq_state_e         state_q,
   output logic [DIV_X_W-1:0] div_x,
   output logic [DIV_Z_W-1:0] div_z,
   output logic               selftest_en,
   output logic               selfinit_en
);
   generate
      if (REG_OUT) begin : g_reg
         // Outputs are computed from the next state so that they change
         // on the same edge as the state register.
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               div_x       <= DIV_X_W'(div_x_of(ST_OFF));
               div_z       <= DIV_Z_W'(div_z_of(ST_OFF));
               selftest_en <= 1'b0;
               selfinit_en <= 1'b0;
            end else begin
               div_x       <= DIV_X_W'(div_x_of(state_d));
               div_z       <= DIV_Z_W'(div_z_of(state_d));
               selftest_en <= (state_d == ST_SELFTEST);
               selfinit_en <= (state_d == ST_SELFINIT);
            end
         end
      end else begin : g_comb
         always_comb begin
            div_x       = DIV_X_W'(div_x_of(state_q));
            div_z       = DIV_Z_W'(div_z_of(state_q));
            selftest_en = (state_q == ST_SELFTEST);
            selfinit_en = (state_q == ST_SELFINIT);
         end
      end
   endgenerate
endmodule

// File: rtl/core_pwr_sequencer.sv
module core_pwr_sequencer
   import core_seq_pkg::*;
#(
   parameter int unsigned RAMP1_CYCLES = 4108,
   parameter int unsigned RAMP_CYCLES  = 4108,
   parameter int unsigned FAULT_CYCLES = 4108,
   parameter int unsigned DIV_X_W      = 5,
   parameter int unsigned DIV_Z_W      = 6,
   parameter bit          REG_OUT      = 1'b1
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               supply_ok,
   input  logic               pwr_good,
   input  logic               core_rst_n,
   input  logic               fwd_rst,
   input  logic               selftest_done,
   input  logic               selfinit_done,
   input  logic               sleep_req,
   input  logic               wake_irq,
   output logic [3:0]         state_code,
   output logic [DIV_X_W-1:0] div_x,
   output logic [DIV_Z_W-1:0] div_z,
   output logic               selftest_en,
   output logic               selfinit_en
);
   localparam int unsigned MAX_A   = (RAMP1_CYCLES > RAMP_CYCLES) ? RAMP1_CYCLES : RAMP_CYCLES;
   localparam int unsigned MAX_DUR = (MAX_A > FAULT_CYCLES) ? MAX_A : FAULT_CYCLES;
   localparam int unsigned CNT_W   = (MAX_DUR > 2) ? $clog2(MAX_DUR) : 1;

   generate
      if (RAMP1_CYCLES < 1 || RAMP_CYCLES < 1 || FAULT_CYCLES < 1) begin : g_bad_dur
         $error("core_pwr_sequencer: every duration must be at least one cycle");
      end
      if ((1 << DIV_X_W) <= DIV_SLOW) begin : g_bad_xw
         $error("core_pwr_sequencer: DIV_X_W too narrow for the slowest divisor");
      end
      if ((1 << DIV_Z_W) <= 2 * DIV_SLOW) begin : g_bad_zw
         $error("core_pwr_sequencer: DIV_Z_W too narrow for the slowest divisor");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic             timer_done;
   logic             tmr_load, tmr_timed;
   logic [CNT_W-1:0] tmr_val;

   core_seq_fsm u_fsm (
      .clk           (clk),
      .por_n         (por_n),
      .supply_ok     (supply_ok),
      .pwr_good      (pwr_good),
      .core_rst_n    (core_rst_n),
      .fwd_rst       (fwd_rst),
      .selftest_done (selftest_done),
      .selfinit_done (selfinit_done),
      .sleep_req     (sleep_req),
      .wake_irq      (wake_irq),
      .timer_done    (timer_done),
      .state_q       (state_q),
      .state_d       (state_d)
   );

   // Duration selection for the state being entered; count runs N-1 .. 0.
   always_comb begin
      tmr_load  = (state_d != state_q);
      tmr_timed = 1'b1;
      case (dur_of(state_d))
         DUR_RAMP1: tmr_val = CNT_W'(RAMP1_CYCLES - 1);
         DUR_RAMP:  tmr_val = CNT_W'(RAMP_CYCLES - 1);
         DUR_FAULT: tmr_val = CNT_W'(FAULT_CYCLES - 1);
         default: begin
            tmr_val   = '0;
            tmr_timed = 1'b0;
         end
      endcase
   end

   core_seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .por_n    (por_n),
      .load     (tmr_load),
      .timed    (tmr_timed),
      .load_val (tmr_val),
      .done     (timer_done)
   );

   core_seq_outreg #(
      .DIV_X_W (DIV_X_W),
      .DIV_Z_W (DIV_Z_W),
      .REG_OUT (REG_OUT)
   ) u_out (
      .clk         (clk),
      .por_n       (por_n),
      .state_d     (state_d),
      .state_q     (state_q),
      .div_x       (div_x),
      .div_z       (div_z),
      .selftest_en (selftest_en),
      .selfinit_en (selfinit_en)
   );

   assign state_code = state_q;
endmodule

// File: rtl/core_seq_chk.sv
module core_seq_chk #(
   parameter int unsigned RAMP1_CYCLES = 4108,
   parameter int unsigned DIV_X_W      = 5,
   parameter int unsigned DIV_Z_W      = 6
) (
   input logic               clk,
   input logic               por_n,
   input logic [3:0]         state_code,
   input logic [DIV_X_W-1:0] div_x,
   input logic [DIV_Z_W-1:0] div_z,
   input logic               selftest_en,
   input logic               selfinit_en
);
   int unsigned dwell;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                 dwell <= 0;
      else if (state_code == 4'd3) dwell <= dwell + 1;
      else                         dwell <= 0;
   end

   a_r3_ramp1_hold: assert property (@(posedge clk) disable iff (!por_n)
      (state_code == 4'd3 && dwell < RAMP1_CYCLES - 1) |=> state_code == 4'd3);

   a_r3_ramp1_exit: assert property (@(posedge clk) disable iff (!por_n)
      (state_code == 4'd3 && dwell == RAMP1_CYCLES - 1) |=> state_code == 4'd4);

   a_r4_upb_succ: assert property (@(posedge clk) disable iff (!por_n)
      (state_code == 4'd4) |=> (state_code == 4'd4 || state_code == 4'd5 || state_code == 4'd7));

   a_r5_en_excl: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0({selftest_en, selfinit_en}));

   a_r5_test_en: assert property (@(posedge clk) disable iff (!por_n)
      selftest_en == (state_code == 4'd5));

   a_r6_run_entry: assert property (@(posedge clk) disable iff (!por_n)
      (state_code == 4'd9 && $past(state_code) != 4'd9) |-> $past(state_code) == 4'd8);

   a_r8_dnc_succ: assert property (@(posedge clk) disable iff (!por_n)
      (state_code == 4'd12) |=> (state_code == 4'd12 || state_code == 4'd13 || state_code == 4'd14));

   a_r12_fast_div: assert property (@(posedge clk) disable iff (!por_n)
      (state_code >= 4'd4 && state_code <= 4'd10) |-> (div_x == 1 && div_z == 2));

   a_r12_slow_div: assert property (@(posedge clk) disable iff (!por_n)
      (state_code <= 4'd2 || state_code >= 4'd12) |-> (div_x == 16 && div_z == 32));
endmodule

bind core_pwr_sequencer core_seq_chk #(
   .RAMP1_CYCLES (RAMP1_CYCLES),
   .DIV_X_W      (DIV_X_W),
   .DIV_Z_W      (DIV_Z_W)
) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .state_code  (state_code),
   .div_x       (div_x),
   .div_z       (div_z),
   .selftest_en (selftest_en),
   .selfinit_en (selfinit_en)
);

// File: tb/core_pwr_sequencer_tb_top.sv
`timescale 1ns/1ps
module core_pwr_sequencer_tb_top;
   localparam int R1C = 12;
   localparam int RC  = 5;
   localparam int FC  = 4;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic supply_ok = 1'b0, pwr_good = 1'b0, core_rst_n = 1'b0, fwd_rst = 1'b0;
   logic selftest_done = 1'b0, selfinit_done = 1'b0, sleep_req = 1'b0, wake_irq = 1'b0;
   logic [3:0] state_code;
   logic [4:0] div_x;
   logic [5:0] div_z;
   logic selftest_en, selfinit_en;

   int n_chk = 0;
   int n_fail = 0;
   bit mon_en = 1'b0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   core_pwr_sequencer #(
      .RAMP1_CYCLES (R1C),
      .RAMP_CYCLES  (RC),
      .FAULT_CYCLES (FC)
   ) dut_i (
      .clk (clk), .por_n (por_n), .supply_ok (supply_ok), .pwr_good (pwr_good),
      .core_rst_n (core_rst_n), .fwd_rst (fwd_rst), .selftest_done (selftest_done),
      .selfinit_done (selfinit_done), .sleep_req (sleep_req), .wake_irq (wake_irq),
      .state_code (state_code), .div_x (div_x), .div_z (div_z),
      .selftest_en (selftest_en), .selfinit_en (selfinit_en)
   );

   function automatic int exp_x(int code);
      if (code == 3 || code == 11) return 2;
      if (code >= 4 && code <= 10) return 1;
      return 16;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Count cycles spent in the current state from its first observed cycle.
   task automatic dwell(int code, int len, string req);
      int cnt = 0;
      check(req, state_code, code);
      while (state_code == 4'(code) && cnt < 1000) begin
         cnt++;
         @(negedge clk);
      end
      check(req, cnt, len);
   endtask

   task automatic hold(int cycles, int code, string req);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         check(req, state_code, code);
      end
   endtask

   // R12: per-cycle table of divisors and enables.
   always @(negedge clk) begin
      if (mon_en) begin
         check("R12 div_x", div_x, exp_x(state_code));
         check("R12 div_z", div_z, 2 * exp_x(state_code));
         check("R12 selftest_en", selftest_en, state_code == 4'd5);
         check("R12 selfinit_en", selfinit_en, state_code == 4'd6);
      end
   end

   task automatic fwd_to_run();
      fwd_rst = 1'b1;
      @(negedge clk); check("R6 fwd_b", state_code, 8);
      fwd_rst = 1'b0;
      @(negedge clk); check("R6 run", state_code, 9);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state, inputs ignored while cleared
      supply_ok = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 state", state_code, 0);
      check("R1 div_x", div_x, 16);
      check("R1 div_z", div_z, 32);
      check("R1 enables", {selftest_en, selfinit_en}, 0);
      supply_ok = 1'b0;
      por_n = 1'b1;
      mon_en = 1'b1;
      @(negedge clk); check("R2 no supply", state_code, 0);
      supply_ok = 1'b1;
      @(negedge clk); check("R2 settle", state_code, 1);
      hold(2, 1, "R2 settle wait");
      pwr_good = 1'b1;
      @(negedge clk); check("R2 lock", state_code, 2);
      // R11: unrelated inputs ignored in LOCK
      selftest_done = 1'b1; wake_irq = 1'b1; fwd_rst = 1'b1;
      hold(3, 2, "R11 lock ignores");
      selftest_done = 1'b0; wake_irq = 1'b0; fwd_rst = 1'b0;
      // Cold boot ramp
      core_rst_n = 1'b1;
      @(negedge clk);
      dwell(3, R1C, "R3 ramp1 length");
      dwell(4, RC, "R4 ramp2 length");
      check("R4 cold to selftest", state_code, 5);
      selfinit_done = 1'b1;
      @(negedge clk); check("R11 selftest ignores selfinit_done", state_code, 5);
      check("R5 selftest_en", selftest_en, 1);
      selfinit_done = 1'b0; selftest_done = 1'b1;
      @(negedge clk); check("R5 selfinit", state_code, 6);
      selftest_done = 1'b0;
      check("R5 selfinit_en", selfinit_en, 1);
      hold(2, 6, "R5 selfinit wait");
      selfinit_done = 1'b1;
      @(negedge clk); check("R5 to fwd_a", state_code, 7);
      selfinit_done = 1'b0;
      hold(2, 7, "R6 fwd_a wait");
      fwd_to_run();
      hold(3, 9, "R6 run stays");
      // Sleep and wake
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      dwell(10, RC, "R7 down1");
      dwell(11, RC, "R7 down2");
      dwell(12, RC, "R7 down3");
      check("R8 sleep", state_code, 13);
      hold(3, 13, "R8 sleep stays");
      wake_irq = 1'b1;
      @(negedge clk);
      wake_irq = 1'b0;
      dwell(3, R1C, "R9 wake ramp1");
      dwell(4, RC, "R9 wake ramp2");
      check("R9 skip self-check", state_code, 7);
      fwd_to_run();
      // Reset-driven ramp down and fault recovery
      core_rst_n = 1'b0;
      @(negedge clk);
      dwell(10, RC, "R7 rst down1");
      dwell(11, RC, "R7 rst down2");
      dwell(12, RC, "R7 rst down3");
      check("R8 hold", state_code, 14);
      hold(3, 14, "R10 hold stays");
      core_rst_n = 1'b1;
      @(negedge clk);
      dwell(15, FC, "R10 fault length");
      dwell(3, R1C, "R10 ramp1");
      dwell(4, RC, "R10 ramp2");
      check("R10 skip self-check", state_code, 7);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule